// File: doc/BRIEF.md
# Pipeline Operand Bypass Selector

This block decides, for every cycle, where the operands of two in-flight instructions come from. It compares the two ALU source register numbers of the instruction now in the execute stage against the destination register numbers waiting in the execute/memory and memory/writeback pipeline registers. It also compares the store-data register number of the instruction now in the memory stage against the destination of the instruction in writeback. From those comparisons it drives the select codes of three operand multiplexers that sit outside the block: ALU input A, ALU input B and the store-data input of the data memory.

A later writer only counts when its stage holds a valid instruction, its register-write enable is set and its destination is not register 0. When both later stages write the same register, the younger one (execute/memory) wins. The result of a load still in the execute/memory register is not yet available, so a match there forwards nothing and does not fall back to the older stage; the stall logic outside this block bubbles that case. A load in writeback may feed the store data of the instruction right behind it, which removes the stall for a load followed by a store of the loaded value.

The block is purely combinational and holds no state; it has no clock or reset input.

Top module: `operand_bypass_unit`

## Requirements
- R1: The ALU select codes are 2'b00 for the register file value, 2'b01 for the execute/memory ALU result and 2'b10 for the memory/writeback result; with no qualifying writer both ALU selects are 2'b00 and 2'b11 never appears.
- R2: An ALU select is 2'b01 when the execute/memory stage is valid, has write enable set, is not a load, and its destination equals that source register number.
- R3: An ALU select is 2'b10 when the memory/writeback stage is valid, has write enable set and its destination equals that source register number, and the execute/memory stage does not qualify as a writer of the same register.
- R4: When both later stages qualify as writers of the same source register, the execute/memory stage wins (2'b01).
- R5: A source or store-data register number of 0 never produces a forward, whatever the later stages hold.
- R6: A stage whose valid bit is clear or whose write enable is clear is never forwarded from, and an invalid younger stage does not hide a valid older writer.
- R7: When the execute/memory stage is a valid, write-enabled load whose destination matches a source register, that ALU select is 2'b00 and does not fall back to the memory/writeback stage.
- R8: The store-data select is 1 (writeback load result) only when the memory/writeback stage is a valid, write-enabled load whose destination equals the nonzero store-data register number; otherwise it is 0 (pipelined B value), including for a non-load writer.
- R9: The A and B selects are decided independently; both may forward from the same or from different stages at once.
- R10: The outputs depend only on the present inputs: they settle in the same cycle the inputs change and a system reset has no effect on them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_a_idx | input | REG_W | Source register number of ALU input A, execute stage |
| ex_src_b_idx | input | REG_W | Source register number of ALU input B, execute stage |
| mem_store_idx | input | REG_W | Store-data register number, memory stage |
| exm_dst_idx | input | REG_W | Destination register, execute/memory register |
| exm_wr_en | input | 1 | Register-write enable, execute/memory register |
| exm_valid | input | 1 | Valid bit, execute/memory register |
| exm_is_load | input | 1 | Load flag, execute/memory register |
| mwb_dst_idx | input | REG_W | Destination register, memory/writeback register |
| mwb_wr_en | input | 1 | Register-write enable, memory/writeback register |
| mwb_valid | input | 1 | Valid bit, memory/writeback register |
| mwb_is_load | input | 1 | Load flag, memory/writeback register |
| alu_a_sel | output | 2 | Select for ALU input A multiplexer |
| alu_b_sel | output | 2 | Select for ALU input B multiplexer |
| store_sel | output | 1 | Select for store-data multiplexer |

## Verification
Every result of this block is due zero cycles after its stimulus, since no register lies between any input and any output. The bench therefore changes inputs one nanosecond after a rising clock edge and samples the selects one nanosecond later, well before the next edge, so no check depends on edge ordering. A reset pulse is applied while a forward is active, and the selects are checked to hold across it.

// File: rtl/bypass_pkg.sv
package bypass_pkg;

    typedef enum logic [1:0] {
        SRC_REGFILE = 2'b00,
        SRC_EXMEM   = 2'b01,
        SRC_MEMWB   = 2'b10
    } alu_src_e;

    typedef enum logic {
        ST_PIPE   = 1'b0,
        ST_LOADWB = 1'b1
    } store_src_e;

    localparam int unsigned NUM_ALU_OPS = 2;

endpackage

// File: rtl/bypass_writer_match.sv
module bypass_writer_match #(
    parameter int unsigned REG_W     = 5,
    parameter bit          ZERO_EXCL = 1'b1
) (
    input  logic [REG_W-1:0] src_idx,
    input  logic [REG_W-1:0] dst_idx,
    input  logic             wr_en,
    input  logic             valid,
    output logic             hit
);
    logic same_reg;
    logic src_live;

    assign same_reg = (src_idx == dst_idx);

    generate
        if (ZERO_EXCL) begin : g_zero_hardwired
            assign src_live = |src_idx;
        end else begin : g_zero_normal
            assign src_live = 1'b1;
        end
    endgenerate

    assign hit = same_reg && src_live && wr_en && valid;

endmodule

// File: rtl/bypass_alu_select.sv
module bypass_alu_select
    import bypass_pkg::*;
(
    input  logic     near_hit,
    input  logic     near_is_load,
    input  logic     far_hit,
    output alu_src_e sel
);
    always_comb begin
        unique case ({near_hit, near_is_load, far_hit})
            3'b100, 3'b101: sel = SRC_EXMEM;
            3'b110, 3'b111: sel = SRC_REGFILE;
            3'b001, 3'b011: sel = SRC_MEMWB;
            default:        sel = SRC_REGFILE;
        endcase
    end

endmodule

// File: rtl/bypass_store_select.sv
module bypass_store_select
    import bypass_pkg::*;
(
    input  logic       wb_hit,
    input  logic       wb_is_load,
    output store_src_e sel
);
    always_comb begin
        unique case ({wb_hit, wb_is_load})
            2'b11:   sel = ST_LOADWB;
            default: sel = ST_PIPE;
        endcase
    end

endmodule

// File: rtl/operand_bypass_unit.sv
module operand_bypass_unit
    import bypass_pkg::*;
#(
    parameter int unsigned REG_W     = 5,
    parameter bit          ZERO_EXCL = 1'b1
) (
    input  logic [REG_W-1:0] ex_src_a_idx,
    input  logic [REG_W-1:0] ex_src_b_idx,
    input  logic [REG_W-1:0] mem_store_idx,
    input  logic [REG_W-1:0] exm_dst_idx,
    input  logic             exm_wr_en,
    input  logic             exm_valid,
    input  logic             exm_is_load,
    input  logic [REG_W-1:0] mwb_dst_idx,
    input  logic             mwb_wr_en,
    input  logic             mwb_valid,
    input  logic             mwb_is_load,
    output logic [1:0]       alu_a_sel,
    output logic [1:0]       alu_b_sel,
    output logic             store_sel
);
    logic [REG_W-1:0] op_idx   [NUM_ALU_OPS];
    alu_src_e         op_sel   [NUM_ALU_OPS];
    logic             near_hit [NUM_ALU_OPS];
    logic             far_hit  [NUM_ALU_OPS];
    logic             st_hit;
    store_src_e       st_sel;

    assign op_idx[0] = ex_src_a_idx;
    assign op_idx[1] = ex_src_b_idx;

    generate
        for (genvar k = 0; k < NUM_ALU_OPS; k++) begin : g_alu_op
            bypass_writer_match #(.REG_W(REG_W), .ZERO_EXCL(ZERO_EXCL)) u_near (
                .src_idx (op_idx[k]),
                .dst_idx (exm_dst_idx),
                .wr_en   (exm_wr_en),
                .valid   (exm_valid),
                .hit     (near_hit[k])
            );
            bypass_writer_match #(.REG_W(REG_W), .ZERO_EXCL(ZERO_EXCL)) u_far (
                .src_idx (op_idx[k]),
                .dst_idx (mwb_dst_idx),
                .wr_en   (mwb_wr_en),
                .valid   (mwb_valid),
                .hit     (far_hit[k])
            );
            bypass_alu_select u_sel (
                .near_hit     (near_hit[k]),
                .near_is_load (exm_is_load),
                .far_hit      (far_hit[k]),
                .sel          (op_sel[k])
            );
        end
    endgenerate

    bypass_writer_match #(.REG_W(REG_W), .ZERO_EXCL(ZERO_EXCL)) u_st_match (
        .src_idx (mem_store_idx),
        .dst_idx (mwb_dst_idx),
        .wr_en   (mwb_wr_en),
        .valid   (mwb_valid),
        .hit     (st_hit)
    );

    bypass_store_select u_st_sel (
        .wb_hit     (st_hit),
        .wb_is_load (mwb_is_load),
        .sel        (st_sel)
    );

    assign alu_a_sel = op_sel[0];
    assign alu_b_sel = op_sel[1];
    assign store_sel = st_sel;

endmodule

// File: rtl/operand_bypass_unit_chk.sv
module operand_bypass_unit_chk #(
    parameter int unsigned REG_W = 5
) (
    input  logic [REG_W-1:0] ex_src_a_idx,
    input  logic [REG_W-1:0] ex_src_b_idx,
    input  logic [REG_W-1:0] mem_store_idx,
    input  logic [REG_W-1:0] exm_dst_idx,
    input  logic             exm_wr_en,
    input  logic             exm_valid,
    input  logic             exm_is_load,
    input  logic [REG_W-1:0] mwb_dst_idx,
    input  logic             mwb_wr_en,
    input  logic             mwb_valid,
    input  logic             mwb_is_load,
    input  logic [1:0]       alu_a_sel,
    input  logic [1:0]       alu_b_sel,
    input  logic             store_sel
);
    always_comb begin
        // R1
        a_code_legal_chk: assert (alu_a_sel != 2'b11 && alu_b_sel != 2'b11)
            else $error("illegal ALU select code");
        // R2
        a_from_exm_chk: assert (alu_a_sel != 2'b01 ||
            (exm_valid && exm_wr_en && !exm_is_load && exm_dst_idx == ex_src_a_idx))
            else $error("A forwarded from execute/memory without qualifying writer");
        // R3
        b_from_mwb_chk: assert (alu_b_sel != 2'b10 ||
            (mwb_valid && mwb_wr_en && mwb_dst_idx == ex_src_b_idx &&
             !(exm_valid && exm_wr_en && exm_dst_idx == ex_src_b_idx)))
            else $error("B forwarded from writeback while not the nearest writer");
        // R5
        zero_never_fwd_chk: assert ((ex_src_a_idx != '0 || alu_a_sel == 2'b00) &&
                                    (ex_src_b_idx != '0 || alu_b_sel == 2'b00) &&
                                    (mem_store_idx != '0 || !store_sel))
            else $error("register 0 forwarded");
        // R8
        store_load_only_chk: assert (!store_sel ||
            (mwb_valid && mwb_wr_en && mwb_is_load && mwb_dst_idx == mem_store_idx))
            else $error("store data bypass without a writeback load");
    end

endmodule

bind operand_bypass_unit operand_bypass_unit_chk #(.REG_W(REG_W)) chk_i (
    .ex_src_a_idx  (ex_src_a_idx),
    .ex_src_b_idx  (ex_src_b_idx),
    .mem_store_idx (mem_store_idx),
    .exm_dst_idx   (exm_dst_idx),
    .exm_wr_en     (exm_wr_en),
    .exm_valid     (exm_valid),
    .exm_is_load   (exm_is_load),
    .mwb_dst_idx   (mwb_dst_idx),
    .mwb_wr_en     (mwb_wr_en),
    .mwb_valid     (mwb_valid),
    .mwb_is_load   (mwb_is_load),
    .alu_a_sel     (alu_a_sel),
    .alu_b_sel     (alu_b_sel),
    .store_sel     (store_sel)
);

// File: tb/operand_bypass_unit_tb_top.sv
module operand_bypass_unit_tb_top;

    localparam int unsigned W = 5;

    typedef struct packed {
        logic [W-1:0] ra;
        logic [W-1:0] rb;
        logic [W-1:0] rst;
        logic [W-1:0] xd;
        logic         xwe;
        logic         xv;
        logic         xld;
        logic [W-1:0] wd;
        logic         wwe;
        logic         wv;
        logic         wld;
        logic [1:0]   ea;
        logic [1:0]   eb;
        logic         es;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{ra:1,  rb:2,  rst:3,  xd:4,  xwe:1, xv:1, xld:0, wd:5,  wwe:1, wv:1, wld:0, ea:0, eb:0, es:0}, // R1 no match
        '{ra:4,  rb:2,  rst:3,  xd:4,  xwe:1, xv:1, xld:0, wd:5,  wwe:1, wv:1, wld:0, ea:1, eb:0, es:0}, // R2
        '{ra:1,  rb:5,  rst:3,  xd:4,  xwe:1, xv:1, xld:0, wd:5,  wwe:1, wv:1, wld:0, ea:0, eb:2, es:0}, // R3
        '{ra:7,  rb:2,  rst:3,  xd:7,  xwe:1, xv:1, xld:0, wd:7,  wwe:1, wv:1, wld:0, ea:1, eb:0, es:0}, // R4
        '{ra:0,  rb:0,  rst:0,  xd:0,  xwe:1, xv:1, xld:0, wd:0,  wwe:1, wv:1, wld:1, ea:0, eb:0, es:0}, // R5
        '{ra:9,  rb:9,  rst:3,  xd:9,  xwe:1, xv:0, xld:0, wd:9,  wwe:1, wv:1, wld:0, ea:2, eb:2, es:0}, // R6 invalid near
        '{ra:9,  rb:1,  rst:3,  xd:9,  xwe:0, xv:1, xld:0, wd:6,  wwe:1, wv:1, wld:0, ea:0, eb:0, es:0}, // R6 no wr_en
        '{ra:1,  rb:6,  rst:3,  xd:4,  xwe:1, xv:1, xld:0, wd:6,  wwe:1, wv:0, wld:0, ea:0, eb:0, es:0}, // R6 wb invalid
        '{ra:8,  rb:3,  rst:3,  xd:8,  xwe:1, xv:1, xld:1, wd:8,  wwe:1, wv:1, wld:0, ea:0, eb:0, es:0}, // R7
        '{ra:1,  rb:2,  rst:12, xd:4,  xwe:1, xv:1, xld:0, wd:12, wwe:1, wv:1, wld:1, ea:0, eb:0, es:1}, // R8
        '{ra:1,  rb:2,  rst:12, xd:4,  xwe:1, xv:1, xld:0, wd:12, wwe:1, wv:1, wld:0, ea:0, eb:0, es:0}, // R8 non-load
        '{ra:1,  rb:2,  rst:12, xd:4,  xwe:1, xv:1, xld:0, wd:12, wwe:1, wv:0, wld:1, ea:0, eb:0, es:0}, // R8 invalid
        '{ra:1,  rb:2,  rst:12, xd:4,  xwe:1, xv:1, xld:0, wd:12, wwe:0, wv:1, wld:1, ea:0, eb:0, es:0}, // R8 no wr_en
        '{ra:10, rb:10, rst:3,  xd:10, xwe:1, xv:1, xld:0, wd:11, wwe:1, wv:1, wld:0, ea:1, eb:1, es:0}, // R9 same
        '{ra:10, rb:11, rst:11, xd:10, xwe:1, xv:1, xld:0, wd:11, wwe:1, wv:1, wld:1, ea:1, eb:2, es:1}, // R9 split
        '{ra:31, rb:31, rst:31, xd:31, xwe:1, xv:1, xld:0, wd:31, wwe:1, wv:1, wld:1, ea:1, eb:1, es:1}, // R4 top reg
        '{ra:1,  rb:2,  rst:0,  xd:4,  xwe:0, xv:0, xld:0, wd:0,  wwe:1, wv:1, wld:1, ea:0, eb:0, es:0}  // R5 store
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] ra, rb, rsd, xd, wd;
    logic         xwe, xv, xld, wwe, wv, wld;
    logic [1:0]   a_sel, b_sel;
    logic         s_sel;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    operand_bypass_unit #(.REG_W(W)) dut_i (
        .ex_src_a_idx  (ra),
        .ex_src_b_idx  (rb),
        .mem_store_idx (rsd),
        .exm_dst_idx   (xd),
        .exm_wr_en     (xwe),
        .exm_valid     (xv),
        .exm_is_load   (xld),
        .mwb_dst_idx   (wd),
        .mwb_wr_en     (wwe),
        .mwb_valid     (wv),
        .mwb_is_load   (wld),
        .alu_a_sel     (a_sel),
        .alu_b_sel     (b_sel),
        .store_sel     (s_sel)
    );

    task automatic apply(input vec_t v);
        @(posedge clk);
        #1;
        ra = v.ra; rb = v.rb; rsd = v.rst;
        xd = v.xd; xwe = v.xwe; xv = v.xv; xld = v.xld;
        wd = v.wd; wwe = v.wwe; wv = v.wv; wld = v.wld;
        #1;
    endtask

    task automatic check(input string req, input logic [1:0] ea,
                         input logic [1:0] eb, input logic es);
        checks++;
        if (a_sel !== ea || b_sel !== eb || s_sel !== es) begin
            errors++;
            $display("FAIL %s: got a=%0d b=%0d s=%0d expected a=%0d b=%0d s=%0d",
                     req, a_sel, b_sel, s_sel, ea, eb, es);
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        vec_t v;
        // R1 R10: idle pipeline during reset gives register-file selects
        v = '0;
        apply(v);
        check("R1 reset idle", 2'b00, 2'b00, 1'b0);

        // R10: reset toggling leaves an active forward untouched
        v = VECS[14];
        apply(v);
        check("R10 before reset release", 2'b01, 2'b10, 1'b1);
        @(posedge clk); #1 rst_n = 1'b1; #1;
        check("R10 after reset release", 2'b01, 2'b10, 1'b1);
        @(posedge clk); #1 rst_n = 1'b0; #1;
        check("R10 reset reasserted", 2'b01, 2'b10, 1'b1);
        @(posedge clk); #1 rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i]);
            check($sformatf("vector %0d (R1..R9 table)", i), VECS[i].ea, VECS[i].eb, VECS[i].es);
        end

        // R5 R2: sweep every register as an execute/memory writer
        for (int r = 0; r < 32; r++) begin
            v = '0;
            v.ra = r[W-1:0]; v.rb = r[W-1:0]; v.rst = r[W-1:0];
            v.xd = r[W-1:0]; v.xwe = 1'b1; v.xv = 1'b1;
            v.wd = r[W-1:0]; v.wwe = 1'b1; v.wv = 1'b1; v.wld = 1'b1;
            apply(v);
            check($sformatf("R5 R2 sweep reg %0d", r),
                  (r == 0) ? 2'b00 : 2'b01, (r == 0) ? 2'b00 : 2'b01, r != 0);
        end

        // R7: load in execute/memory with only an older writer elsewhere
        v = '0;
        v.ra = 6; v.rb = 7; v.xd = 6; v.xwe = 1; v.xv = 1; v.xld = 1;
        v.wd = 7; v.wwe = 1; v.wv = 1;
        apply(v);
        check("R7 load near, other operand from writeback", 2'b00, 2'b10, 1'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule